// File: doc/BRIEF.md
# Host Command and Status Port

This block is the control-side slave of a buffered audio playback system. A host microcontroller talks to it over three wires (serial data, shift clock, latch strobe). Write transfers update the configuration: memory-system controls, audio mute and comparison width, buffer memory size, compression mode, error-capture options, and a five-pin general-purpose port with a direction bit per pin. Read transfers return a status byte or a 16-bit residual count on a serial output line, in step with the host's shift clock.

The rest of the system reports events on dedicated inputs: a write-overflow condition, an input-buffer overflow pulse, a residual-empty level, and an external error flag with its frame clock. The block turns these into sticky flags that the host clears by reading them, and it maintains an encoder-running bit whose stop conditions override its start conditions. Host-side inputs are asynchronous and are sampled through synchronizers in the system clock domain, so the host's shift clock must be several times slower than `clk`.

Top module: `cmdif_top`

## Requirements
- R1: After reset the serial output is low, every configuration output is low, and the compression mode output reads 2 (6-bit mode).
- R2: A write is 16 shift clocks, MSB first, command byte then data byte, and takes effect at the latch. Command 0x80: bit0 memory-on, bits 3:2 connect mode, bit5 read-enable. Command 0x83: bit0 12-bit comparison, bit1 mute. Command 0x85: bits 7:6 memory size, bit5 capture-select, bit4 capture-polarity, bits 3:0 compression one-hot.
- R3: A latch after a bit count other than 16 (write) or 8 (read), or with a command outside 0x80–0x85 / 0x90–0x93, changes no output and starts no readout; commands 0x84 and above 0x85 alter nothing.
- R4: After an 8-clock read command and its latch, the serial output holds the reply MSB; each falling shift-clock edge advances one bit. 0x90, 0x91 and 0x93 return 8 bits, 0x92 returns the 16-bit residual input. The next latch ends the readout without decoding, and the output is low outside a readout.
- R5: Status 0x90 is {error, write overflow, buffer overflow, 0, 0, 0, decode-stopped, 0} from bit7 down; these flags are sticky and cleared by the read that returns them.
- R6: Write overflow is set only at the onset of the overflow input, so a condition still present after a clearing read is not reported again; decode-stopped is set at the onset of residual-empty; buffer overflow is set by any overflow pulse.
- R7: The error flag is captured by {select, polarity}: 00 flag input low at a falling frame-clock edge, 01 low at a rising edge, 10 low at any cycle, 11 high at any cycle.
- R8: The compression output is 3 for one-hot 1000 (full), 2 for 0100 (6-bit), 1 for 0010 (5-bit), 0 for 0001 (4-bit), and 2 for any other pattern.
- R9: Command 0x81 sets pin directions (bits 4:0, 1 = output); command 0x82 updates only output-configured bits of the port data; command 0x93 returns per pin the driven value of an output or the level of an input, upper bits 0.
- R10: Encoder-running is set by 0x80 with bit7 and bit0 high when the error flag is clear and overflow is low; it is cleared by 0x80 with bit7 low, bit0 low or a nonzero connect mode, by an error capture, or while overflow is high; clearing wins over setting.
- R11: Status 0x91 is {residual-empty input, overflow input, encoder-running, 0, 0, 0, 0, 0} from bit7 down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sclk_i | input | 1 | Host shift clock |
| host_sdi_i | input | 1 | Host serial data in |
| host_ld_i | input | 1 | Host latch strobe, high pulse ends a transfer |
| host_sdo_o | output | 1 | Serial reply data to host |
| ovf_i | input | 1 | Write-overflow condition level |
| bovf_i | input | 1 | Input-buffer overflow pulse |
| empty_i | input | 1 | Residual-empty level |
| eflag_i | input | 1 | External error flag |
| eframe_i | input | 1 | Frame clock for error capture |
| residual_i | input | 16 | Residual count returned by 0x92 |
| gp_di_i | input | 5 | General-purpose pin input levels |
| gp_oe_o | output | 5 | General-purpose pin output enables |
| gp_do_o | output | 5 | General-purpose pin output data |
| mem_on_o | output | 1 | Memory system enable |
| rd_en_o | output | 1 | Read (decode) enable |
| conn_mode_o | output | 2 | Connect mode |
| enc_active_o | output | 1 | Encoder-running status |
| mute_o | output | 1 | Forced mute |
| cmp12_o | output | 1 | 12-bit comparison select |
| ram_cfg_o | output | 2 | Buffer memory size code |
| comp_mode_o | output | 2 | Decoded compression mode |

## Verification
A wrong flag or bit counter shows up on the serial output at the next status read: a lost clear repeats a bit, a lost edge misses one, and an off-by-one count either ignores a valid transfer or accepts a short one, visible as an unchanged or changed configuration output a few cycles after the latch. A wrong encoder-running priority appears on `enc_active_o` one cycle after the offending command or overflow, and port masking errors appear immediately on `gp_do_o` and in the next 0x93 reply.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;
  localparam logic [7:0] CMD_MEM  = 8'h80;
  localparam logic [7:0] CMD_DIR  = 8'h81;
  localparam logic [7:0] CMD_PDAT = 8'h82;
  localparam logic [7:0] CMD_AUX  = 8'h83;
  localparam logic [7:0] CMD_OPT  = 8'h85;
  localparam logic [7:0] CMD_ST0  = 8'h90;
  localparam logic [7:0] CMD_ST1  = 8'h91;
  localparam logic [7:0] CMD_RES  = 8'h92;
  localparam logic [7:0] CMD_PIN  = 8'h93;

  typedef enum logic [1:0] {CM_4B = 2'd0, CM_5B = 2'd1, CM_6B = 2'd2, CM_FULL = 2'd3} comp_mode_e;
  typedef enum logic [1:0] {EC_FALL = 2'd0, EC_RISE = 2'd1, EC_LOW = 2'd2, EC_HIGH = 2'd3} ecap_e;

  function automatic comp_mode_e decode_comp(input logic [3:0] oh);
    case (oh)
      4'b1000: return CM_FULL;
      4'b0010: return CM_5B;
      4'b0001: return CM_4B;
      default: return CM_6B;
    endcase
  endfunction
endpackage

// File: rtl/cmdif_sync.sv
module cmdif_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES <= 1) begin : g_one
      logic [W-1:0] st_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st_q <= '0;
        else        st_q <= d_i;
      assign q_o = st_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] st_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st_q <= '0;
        else        st_q <= {st_q[STAGES-2:0], d_i};
      assign q_o = st_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cmdif_serial.sv
module cmdif_serial #(
  parameter int CMD_W = 8,
  parameter int DAT_W = 8,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             sdi_s,
  input  logic             ld_s,
  input  logic [RES_W-1:0] rd_word_i,
  output logic             wr_stb_o,
  output logic             rd_stb_o,
  output logic [CMD_W-1:0] wr_cmd_o,
  output logic [DAT_W-1:0] wr_data_o,
  output logic [CMD_W-1:0] rd_cmd_o,
  output logic             ro_o,
  output logic             sdo_o
);
  import cmdif_pkg::*;
  localparam int WR_BITS = CMD_W + DAT_W;
  localparam int CNT_MAX = WR_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic               sclk_q, ld_q, ro_q, ro_d;
  logic [WR_BITS-1:0] rx_q, rx_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [RES_W-1:0]   tx_q, tx_d;
  logic               sclk_rise, sclk_fall, ld_rise, wr_ok, rd_ok;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign ld_rise   = ld_s & ~ld_q;
  assign wr_cmd_o  = rx_q[WR_BITS-1:DAT_W];
  assign wr_data_o = rx_q[DAT_W-1:0];
  assign rd_cmd_o  = rx_q[CMD_W-1:0];

  always_comb begin
    wr_ok = ld_rise && !ro_q && (cnt_q == CNT_W'(WR_BITS))
            && (wr_cmd_o >= CMD_MEM) && (wr_cmd_o <= CMD_OPT);
    rd_ok = ld_rise && !ro_q && (cnt_q == CNT_W'(CMD_W))
            && (rd_cmd_o >= CMD_ST0) && (rd_cmd_o <= CMD_PIN);
    cnt_d = cnt_q;
    rx_d  = rx_q;
    ro_d  = ro_q;
    tx_d  = tx_q;
    if (ld_rise) begin
      cnt_d = '0;
      ro_d  = rd_ok;
      if (!rd_ok)                 tx_d = '0;
      else if (rd_cmd_o == CMD_RES) tx_d = rd_word_i;
      else                        tx_d = {rd_word_i[CMD_W-1:0], {(RES_W-CMD_W){1'b0}}};
    end else begin
      if (sclk_rise) begin
        rx_d = {rx_q[WR_BITS-2:0], sdi_s};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
      end
      if (sclk_fall && ro_q) tx_d = {tx_q[RES_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ld_q   <= 1'b0;
      ro_q   <= 1'b0;
      rx_q   <= '0;
      cnt_q  <= '0;
      tx_q   <= '0;
    end else begin
      sclk_q <= sclk_s;
      ld_q   <= ld_s;
      ro_q   <= ro_d;
      rx_q   <= rx_d;
      cnt_q  <= cnt_d;
      tx_q   <= tx_d;
    end

  assign wr_stb_o = wr_ok;
  assign rd_stb_o = rd_ok;
  assign ro_o     = ro_q;
  assign sdo_o    = tx_q[RES_W-1] & ro_q;
endmodule

// File: rtl/cmdif_regs.sv
module cmdif_regs #(
  parameter int GP_W  = 5,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb_i,
  input  logic             rd_stb_i,
  input  logic [7:0]       wr_cmd_i,
  input  logic [7:0]       wr_data_i,
  input  logic [7:0]       rd_cmd_i,
  input  logic             ovf_i,
  input  logic             bovf_i,
  input  logic             empty_i,
  input  logic             eflag_s,
  input  logic             eframe_s,
  input  logic [GP_W-1:0]  gp_di_s,
  input  logic [RES_W-1:0] residual_i,
  output logic [RES_W-1:0] rd_word_o,
  output logic             mem_on_o,
  output logic             rd_en_o,
  output logic [1:0]       conn_mode_o,
  output logic             enc_active_o,
  output logic             mute_o,
  output logic             cmp12_o,
  output logic [1:0]       ram_cfg_o,
  output logic [1:0]       comp_mode_o,
  output logic [GP_W-1:0]  gp_oe_o,
  output logic [GP_W-1:0]  gp_do_o,
  output logic             wovf_o
);
  import cmdif_pkg::*;
  localparam logic [7:0] OPT_RST = 8'h04;

  logic            mem_on_q, rd_en_q, enc_q, mute_q, cmp12_q;
  logic [1:0]      conn_q;
  logic [7:0]      opt_q;
  logic [GP_W-1:0] dir_q, do_q;
  logic            err_q, wovf_q, bovf_q, dstop_q, ovf_q, empty_q, eframe_q;
  logic            mem_on_d, rd_en_d, enc_d, mute_d, cmp12_d;
  logic [1:0]      conn_d;
  logic [7:0]      opt_d;
  logic [GP_W-1:0] dir_d, do_d, pin_view;
  logic            err_d, wovf_d, bovf_d, dstop_d;
  logic            wr_mem, wr_dir, wr_pdat, wr_aux, wr_opt, clr_st0, err_hit, enc_set, enc_rst;
  ecap_e           ec;

  always_comb begin
    wr_mem  = wr_stb_i && (wr_cmd_i == CMD_MEM);
    wr_dir  = wr_stb_i && (wr_cmd_i == CMD_DIR);
    wr_pdat = wr_stb_i && (wr_cmd_i == CMD_PDAT);
    wr_aux  = wr_stb_i && (wr_cmd_i == CMD_AUX);
    wr_opt  = wr_stb_i && (wr_cmd_i == CMD_OPT);
    clr_st0 = rd_stb_i && (rd_cmd_i == CMD_ST0);
    ec      = ecap_e'(opt_q[5:4]);
    case (ec)
      EC_FALL: err_hit = !eframe_s && eframe_q && !eflag_s;
      EC_RISE: err_hit = eframe_s && !eframe_q && !eflag_s;
      EC_LOW:  err_hit = !eflag_s;
      default: err_hit = eflag_s;
    endcase
    err_d   = (err_q & ~clr_st0) | err_hit;
    wovf_d  = (wovf_q & ~clr_st0) | (ovf_i & ~ovf_q);
    bovf_d  = (bovf_q & ~clr_st0) | bovf_i;
    dstop_d = (dstop_q & ~clr_st0) | (empty_i & ~empty_q);
    enc_set = wr_mem && wr_data_i[7] && wr_data_i[0] && !err_q && !ovf_i;
    enc_rst = (wr_mem && (!wr_data_i[7] || !wr_data_i[0] || (wr_data_i[3:2] != 2'b00)))
              || err_hit || ovf_i;
    if (enc_rst)      enc_d = 1'b0;
    else if (enc_set) enc_d = 1'b1;
    else              enc_d = enc_q;
    mem_on_d = wr_mem ? wr_data_i[0]   : mem_on_q;
    conn_d   = wr_mem ? wr_data_i[3:2] : conn_q;
    rd_en_d  = wr_mem ? wr_data_i[5]   : rd_en_q;
    cmp12_d  = wr_aux ? wr_data_i[0]   : cmp12_q;
    mute_d   = wr_aux ? wr_data_i[1]   : mute_q;
    opt_d    = wr_opt ? wr_data_i      : opt_q;
    dir_d    = wr_dir ? wr_data_i[GP_W-1:0] : dir_q;
    do_d     = wr_pdat ? ((do_q & ~dir_q) | (wr_data_i[GP_W-1:0] & dir_q)) : do_q;
    pin_view = (dir_q & do_q) | (~dir_q & gp_di_s);
    case (rd_cmd_i)
      CMD_ST0: rd_word_o = RES_W'({err_q, wovf_q, bovf_q, 3'b000, dstop_q, 1'b0});
      CMD_ST1: rd_word_o = RES_W'({empty_i, ovf_i, enc_q, 5'b00000});
      CMD_RES: rd_word_o = residual_i;
      CMD_PIN: rd_word_o = RES_W'(pin_view);
      default: rd_word_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mem_on_q <= 1'b0; rd_en_q <= 1'b0; enc_q <= 1'b0; mute_q <= 1'b0; cmp12_q <= 1'b0;
      conn_q <= '0; opt_q <= OPT_RST; dir_q <= '0; do_q <= '0;
      err_q <= 1'b0; wovf_q <= 1'b0; bovf_q <= 1'b0; dstop_q <= 1'b0;
      ovf_q <= 1'b0; empty_q <= 1'b0; eframe_q <= 1'b0;
    end else begin
      mem_on_q <= mem_on_d; rd_en_q <= rd_en_d; enc_q <= enc_d; mute_q <= mute_d; cmp12_q <= cmp12_d;
      conn_q <= conn_d; opt_q <= opt_d; dir_q <= dir_d; do_q <= do_d;
      err_q <= err_d; wovf_q <= wovf_d; bovf_q <= bovf_d; dstop_q <= dstop_d;
      ovf_q <= ovf_i; empty_q <= empty_i; eframe_q <= eframe_s;
    end

  assign mem_on_o     = mem_on_q;
  assign rd_en_o      = rd_en_q;
  assign conn_mode_o  = conn_q;
  assign enc_active_o = enc_q;
  assign mute_o       = mute_q;
  assign cmp12_o      = cmp12_q;
  assign ram_cfg_o    = opt_q[7:6];
  assign comp_mode_o  = 2'(decode_comp(opt_q[3:0]));
  assign gp_oe_o      = dir_q;
  assign gp_do_o      = do_q;
  assign wovf_o       = wovf_q;
endmodule

// File: rtl/cmdif_top.sv
module cmdif_top #(
  parameter int GP_W        = 5,
  parameter int RES_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sclk_i,
  input  logic             host_sdi_i,
  input  logic             host_ld_i,
  output logic             host_sdo_o,
  input  logic             ovf_i,
  input  logic             bovf_i,
  input  logic             empty_i,
  input  logic             eflag_i,
  input  logic             eframe_i,
  input  logic [RES_W-1:0] residual_i,
  input  logic [GP_W-1:0]  gp_di_i,
  output logic [GP_W-1:0]  gp_oe_o,
  output logic [GP_W-1:0]  gp_do_o,
  output logic             mem_on_o,
  output logic             rd_en_o,
  output logic [1:0]       conn_mode_o,
  output logic             enc_active_o,
  output logic             mute_o,
  output logic             cmp12_o,
  output logic [1:0]       ram_cfg_o,
  output logic [1:0]       comp_mode_o
);
  localparam int CMD_W  = 8;
  localparam int DAT_W  = 8;
  localparam int SYNC_W = 5 + GP_W;

  logic [SYNC_W-1:0] sync_q;
  logic              sclk_s, sdi_s, ld_s, eflag_s, eframe_s;
  logic [GP_W-1:0]   gp_di_s;
  logic              wr_stb_w, rd_stb_w, ro_w, wovf_w;
  logic [CMD_W-1:0]  wr_cmd_w, rd_cmd_w;
  logic [DAT_W-1:0]  wr_data_w;
  logic [RES_W-1:0]  rd_word_w;

  cmdif_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({host_sclk_i, host_sdi_i, host_ld_i, eflag_i, eframe_i, gp_di_i}),
    .q_o(sync_q)
  );
  assign {sclk_s, sdi_s, ld_s, eflag_s, eframe_s, gp_di_s} = sync_q;

  cmdif_serial #(.CMD_W(CMD_W), .DAT_W(DAT_W), .RES_W(RES_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sdi_s(sdi_s), .ld_s(ld_s),
    .rd_word_i(rd_word_w), .wr_stb_o(wr_stb_w), .rd_stb_o(rd_stb_w),
    .wr_cmd_o(wr_cmd_w), .wr_data_o(wr_data_w), .rd_cmd_o(rd_cmd_w),
    .ro_o(ro_w), .sdo_o(host_sdo_o)
  );

  cmdif_regs #(.GP_W(GP_W), .RES_W(RES_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb_w), .rd_stb_i(rd_stb_w),
    .wr_cmd_i(wr_cmd_w), .wr_data_i(wr_data_w), .rd_cmd_i(rd_cmd_w),
    .ovf_i(ovf_i), .bovf_i(bovf_i), .empty_i(empty_i),
    .eflag_s(eflag_s), .eframe_s(eframe_s), .gp_di_s(gp_di_s),
    .residual_i(residual_i), .rd_word_o(rd_word_w),
    .mem_on_o(mem_on_o), .rd_en_o(rd_en_o), .conn_mode_o(conn_mode_o),
    .enc_active_o(enc_active_o), .mute_o(mute_o), .cmp12_o(cmp12_o),
    .ram_cfg_o(ram_cfg_o), .comp_mode_o(comp_mode_o),
    .gp_oe_o(gp_oe_o), .gp_do_o(gp_do_o), .wovf_o(wovf_w)
  );
endmodule

// File: rtl/cmdif_chk.sv
module cmdif_chk #(
  parameter int GP_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ovf_i,
  input logic            enc_active_o,
  input logic            mem_on_o,
  input logic            host_sdo_o,
  input logic            ro_i,
  input logic            wr_stb_i,
  input logic            wovf_i,
  input logic [GP_W-1:0] gp_oe_o,
  input logic [GP_W-1:0] gp_do_o
);
  // R10: overflow stops the encoder on the next cycle
  a_r10_ovf_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> !enc_active_o);
  // R10: encoder never runs with the memory system off
  a_r10_enc_needs_mem: assert property (@(posedge clk) disable iff (!rst_n)
    enc_active_o |-> mem_on_o);
  // R4: serial reply line is quiet outside a readout
  a_r4_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ro_i |-> !host_sdo_o);
  // R9: input-configured port bits keep their data
  a_r9_input_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((gp_do_o ^ $past(gp_do_o)) & ~$past(gp_oe_o)) == '0);
  // R6: write overflow flag rises only after the overflow input was high
  a_r6_wovf_onset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wovf_i) |-> $past(ovf_i));
  // R2: configuration moves only after an accepted write
  a_r2_latch_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stb_i) |-> $stable(mem_on_o));
endmodule

bind cmdif_top cmdif_chk #(.GP_W(GP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ovf_i(ovf_i), .enc_active_o(enc_active_o),
  .mem_on_o(mem_on_o), .host_sdo_o(host_sdo_o), .ro_i(ro_w),
  .wr_stb_i(wr_stb_w), .wovf_i(wovf_w), .gp_oe_o(gp_oe_o), .gp_do_o(gp_do_o)
);

// File: tb/cmdif_top_tb_top.sv
module cmdif_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // {op, cmd, data, expected}; op 0 write, 1 8-bit read, 2 16-bit read
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd0, 8'h81, 8'h15, 16'h0000},
    {2'd0, 8'h82, 8'h1F, 16'h0000},
    {2'd1, 8'h93, 8'h00, 16'h0017},
    {2'd0, 8'h81, 8'h03, 16'h0000},
    {2'd1, 8'h93, 8'h00, 16'h0001},
    {2'd0, 8'h82, 8'h02, 16'h0000},
    {2'd1, 8'h93, 8'h00, 16'h0002},
    {2'd2, 8'h92, 8'h00, 16'hA5C3},
    {2'd1, 8'h91, 8'h00, 16'h0000},
    {2'd0, 8'h80, 8'h81, 16'h0000},
    {2'd1, 8'h91, 8'h00, 16'h0020},
    {2'd0, 8'h80, 8'h85, 16'h0000},
    {2'd1, 8'h91, 8'h00, 16'h0000},
    {2'd1, 8'h90, 8'h00, 16'h0000}
  };

  logic clk, rst_n, sclk, sdi, ld, ovf, bovf, empty, eflag, eframe;
  logic [15:0] residual;
  logic [4:0]  gp_di, gp_oe, gp_do;
  logic sdo, mem_on, rd_en, enc, mute, cmp12;
  logic [1:0] conn, ram_cfg, comp;
  int n_chk, n_fail;
  logic [15:0] rv;

  cmdif_top dut_i (
    .clk(clk), .rst_n(rst_n), .host_sclk_i(sclk), .host_sdi_i(sdi), .host_ld_i(ld),
    .host_sdo_o(sdo), .ovf_i(ovf), .bovf_i(bovf), .empty_i(empty), .eflag_i(eflag),
    .eframe_i(eframe), .residual_i(residual), .gp_di_i(gp_di), .gp_oe_o(gp_oe),
    .gp_do_o(gp_do), .mem_on_o(mem_on), .rd_en_o(rd_en), .conn_mode_o(conn),
    .enc_active_o(enc), .mute_o(mute), .cmp12_o(cmp12), .ram_cfg_o(ram_cfg),
    .comp_mode_o(comp)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      wait_clk(2); sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(2);
    end
  endtask

  task automatic latch();
    ld = 1'b1; wait_clk(4); ld = 1'b0; wait_clk(6);
  endtask

  task automatic wr(input logic [7:0] c, input logic [7:0] d);
    host_bits({16'h0, c, d}, 16);
    latch();
  endtask

  task automatic rd(input logic [7:0] c, input int n, output logic [15:0] v);
    host_bits({24'h0, c}, 8);
    latch();
    v = '0;
    for (int i = 0; i < n; i++) begin
      v = {v[14:0], sdo};
      sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4);
    end
    latch();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; sclk = 0; sdi = 0; ld = 0; ovf = 0; bovf = 0; empty = 0;
    eflag = 1'b1; eframe = 1'b0; residual = 16'hA5C3; gp_di = 5'b00011;
    wait_clk(5); rst_n = 1'b1; wait_clk(5);
    // R1 reset state
    chk("R1 sdo", 16'(sdo), 16'h0);
    chk("R1 mem_on/enc/mute/cmp12", {12'h0, mem_on, enc, mute, cmp12}, 16'h0);
    chk("R1 comp", 16'(comp), 16'h2);
    chk("R1 port", {6'h0, gp_oe, gp_do}, 16'h0);
    chk("R1 ram/conn/rd_en", {11'h0, ram_cfg, conn, rd_en}, 16'h0);

    // R9 R4 R11 R10 R5: vector table
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][33:32] == 2'd0) wr(VEC[k][31:24], VEC[k][23:16]);
      else begin
        rd(VEC[k][31:24], (VEC[k][33:32] == 2'd2) ? 16 : 8, rv);
        chk($sformatf("R4/R9/R11 vector %0d", k), rv, VEC[k][15:0]);
      end
    end
    chk("R9 port outputs", {6'h0, gp_oe, gp_do}, {6'h0, 5'b00011, 5'b10110});
    chk("R10 conn stops encoder", 16'(enc), 16'h0);

    // R2 field decoding
    wr(8'h80, 8'h2D);
    chk("R2 mem fields", {11'h0, mem_on, conn, rd_en, enc}, {11'h0, 1'b1, 2'b11, 1'b1, 1'b0});
    wr(8'h83, 8'h02);
    chk("R2 mute", {14'h0, mute, cmp12}, 16'h2);
    wr(8'h83, 8'h01);
    chk("R2 cmp12", {14'h0, mute, cmp12}, 16'h1);

    // R8 compression decode
    wr(8'h85, 8'h08); chk("R8 full", 16'(comp), 16'h3);
    wr(8'h85, 8'h02); chk("R8 5-bit", 16'(comp), 16'h1);
    wr(8'h85, 8'h01); chk("R8 4-bit", 16'(comp), 16'h0);
    wr(8'h85, 8'h00); chk("R8 none set", 16'(comp), 16'h2);
    wr(8'h85, 8'h0C); chk("R8 two set", 16'(comp), 16'h2);
    wr(8'h85, 8'hC4); chk("R2 ram size", {14'h0, ram_cfg}, 16'h3);
    wr(8'h85, 8'h04);

    // R3 discarded transfers
    host_bits(32'h8302 >> 1, 15); latch();
    chk("R3 15 clocks", {14'h0, mute, cmp12}, 16'h1);
    host_bits(32'h08302, 17); latch();
    chk("R3 17 clocks", {14'h0, mute, cmp12}, 16'h1);
    wr(8'h84, 8'hFF);
    wr(8'h86, 8'hFF);
    chk("R3 unknown writes", {12'h0, comp, mute, cmp12}, 16'h9);
    host_bits(32'h90 >> 1, 7); latch();
    chk("R3 short read", 16'(sdo), 16'h0);
    host_bits(32'h0090, 16); latch();
    chk("R3 long read", 16'(sdo), 16'h0);
    wr(8'h83, 8'h00);
    chk("R3 no readout entered", 16'(cmp12), 16'h0);

    // R7 mode 00: falling frame edge only
    eflag = 1'b0; eframe = 1'b1; wait_clk(6);
    rd(8'h90, 8, rv); chk("R7 mode00 rise ignored", rv, 16'h00);
    eframe = 1'b0; wait_clk(6); eflag = 1'b1; wait_clk(4);
    rd(8'h90, 8, rv); chk("R7 mode00 fall", rv, 16'h80);
    rd(8'h90, 8, rv); chk("R5 cleared by read", rv, 16'h00);
    // mode 01
    wr(8'h85, 8'h14);
    eflag = 1'b0; eframe = 1'b1; wait_clk(6);
    rd(8'h90, 8, rv); chk("R7 mode01 rise", rv, 16'h80);
    eframe = 1'b0; wait_clk(6); eflag = 1'b1; wait_clk(4);
    rd(8'h90, 8, rv); chk("R7 mode01 fall ignored", rv, 16'h00);
    // mode 10
    wr(8'h85, 8'h24);
    rd(8'h90, 8, rv); chk("R7 mode10 high ignored", rv, 16'h00);
    eflag = 1'b0; wait_clk(4); eflag = 1'b1; wait_clk(4);
    rd(8'h90, 8, rv); chk("R7 mode10 low", rv, 16'h80);
    // mode 11
    eflag = 1'b0; wait_clk(4);
    wr(8'h85, 8'h34);
    rd(8'h90, 8, rv);
    rd(8'h90, 8, rv); chk("R7 mode11 low ignored", rv, 16'h00);
    eflag = 1'b1; wait_clk(4); eflag = 1'b0; wait_clk(4);
    rd(8'h90, 8, rv); chk("R7 mode11 high", rv, 16'h80);
    wr(8'h85, 8'h04);
    eflag = 1'b1; wait_clk(4);
    rd(8'h90, 8, rv);

    // R10 error interaction
    wr(8'h80, 8'h81); chk("R10 start", 16'(enc), 16'h1);
    eflag = 1'b0; eframe = 1'b1; wait_clk(6); eframe = 1'b0; wait_clk(6); eflag = 1'b1; wait_clk(2);
    chk("R10 error stops", 16'(enc), 16'h0);
    wr(8'h80, 8'h81); chk("R10 start blocked by error", 16'(enc), 16'h0);
    rd(8'h90, 8, rv); chk("R5 error seen", rv, 16'h80);
    wr(8'h80, 8'h81); chk("R10 restart", 16'(enc), 16'h1);
    wr(8'h80, 8'h80); chk("R10 memory off stops", 16'(enc), 16'h0);

    // R6 R11 overflow, buffer overflow, empty
    wr(8'h80, 8'h81);
    ovf = 1'b1; wait_clk(3);
    chk("R10 overflow stops", 16'(enc), 16'h0);
    rd(8'h90, 8, rv); chk("R6 write overflow", rv, 16'h40);
    rd(8'h90, 8, rv); chk("R6 once only", rv, 16'h00);
    rd(8'h91, 8, rv); chk("R11 overflow level", rv, 16'h40);
    wr(8'h80, 8'h81); chk("R10 start blocked by overflow", 16'(enc), 16'h0);
    ovf = 1'b0; wait_clk(2);
    bovf = 1'b1; wait_clk(1); bovf = 1'b0; wait_clk(2);
    rd(8'h90, 8, rv); chk("R6 buffer overflow", rv, 16'h20);
    empty = 1'b1; wait_clk(2);
    rd(8'h91, 8, rv); chk("R11 empty level", rv, 16'h80);
    rd(8'h90, 8, rv); chk("R6 decode stopped", rv, 16'h02);
    rd(8'h90, 8, rv); chk("R6 empty once", rv, 16'h00);
    empty = 1'b0;

    // R1 reset mid-run
    rst_n = 1'b0; wait_clk(3); rst_n = 1'b1; wait_clk(3);
    chk("R1 reset again", {9'h0, mem_on, rd_en, conn, comp, gp_oe[0]}, 16'h04);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule